// File: doc/BRIEF.md
# Odd-Integer Sequential Square Root

This block finds the integer square root of an unsigned binary radicand. It relies on the fact that the first k odd numbers add up to k squared. The value 2d+1 is never built. Each root step instead makes two single-cycle subtractions from a running remainder: first the current divisor d, then d+1. Whenever a whole step finishes without going negative, the divisor and the root tally both advance by one. The only arithmetic the block needs is one shared subtractor and one incrementer.

A caller holds the operand on `radicand_i` and raises `start_i` for one clock while the block is idle. When the first subtraction goes negative, the block stops and pulses `done_o` for one cycle. The root and remainder are then ready, and they stay unchanged until the next result is produced. A remainder of zero does not stop the block. Only an overdraft stops it.

Top module: `oddsum_isqrt`

## Requirements
- R1: After reset, `done_o` is low and `root_o` and `rem_o` both read 0.
- R2: When `done_o` pulses, `root_o` equals floor(sqrt(N)) for the radicand N captured at the accepted start. This covers the inputs 0 and 2^RAD_W-1.
- R3: When `done_o` pulses, `rem_o` equals N - root². This is the value the running remainder had before the step that overdrew. It is never larger than 2·root.
- R4: `done_o` is high for exactly one cycle for each accepted start.
- R5: `root_o` and `rem_o` change only in the cycle where `done_o` rises. They hold their values for every cycle after that, until the next result.
- R6: A `start_i` pulse that arrives while a computation is in progress is ignored. The result and the timing of the run in progress are unchanged.
- R7: Let r be the root and e = N - r². The number of rising edges from the edge that samples `start_i` up to and including the edge that raises `done_o` is 2r+1 when e < r, and 2r+2 otherwise.
- R8: The first subtraction of a step removes d and the second removes d+1. The first subtraction of the first step (d = 0) never overdraws.
- R9: After a step completes without overdraft, the divisor goes up by exactly one. A zero remainder does not end the run. For example, N = 16 gives root 4 and remainder 0 after the fifth step overdraws.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin; it is honoured only while idle |
| radicand_i | input | RAD_W | Unsigned operand, sampled together with start_i |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| root_o | output | RAD_W/2 | Integer square root |
| rem_o | output | RAD_W/2+1 | N minus root squared |

## Verification
The corner cases of this block are perfect squares, where the remainder reaches zero partway through a run, and the values just below and just above a square. These cases separate an overdraft on the first subtraction of a step from one on the second. If a design stopped at zero, or compared against the wrong divisor, the root or the cycle count would be off by one step. A design that restored the wrong partial value would report N - r² - r in place of N - r². The zero radicand and the all-ones radicand check the divisor width and the first-step rule. A second start issued during a long run checks that the operands cannot be reloaded while the block is busy.

// File: rtl/oddsum_isqrt_pkg.sv
package oddsum_isqrt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SUBA = 2'd1,
    ST_SUBB = 2'd2
  } step_e;
endpackage

// File: rtl/oddsum_sub.sv
module oddsum_sub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] diff_o,
  output logic         borrow_o
);
  logic [W:0] full;
  always_comb begin
    full     = {1'b0, a_i} - {1'b0, b_i};
    diff_o   = full[W-1:0];
    borrow_o = full[W];
  end
endmodule

// File: rtl/oddsum_ctrl.sv
module oddsum_ctrl
  import oddsum_isqrt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic borrow_i,
  output logic load_o,
  output logic phase_b_o,
  output logic commit_a_o,
  output logic commit_b_o,
  output logic finish_o,
  output logic done_o
);
  step_e state_q, state_d;
  logic  done_q;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    commit_a_o = 1'b0;
    commit_b_o = 1'b0;
    finish_o   = 1'b0;
    phase_b_o  = (state_q == ST_SUBB);
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_SUBA;
        end
      end
      ST_SUBA: begin
        if (borrow_i) begin
          finish_o = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          commit_a_o = 1'b1;
          state_d    = ST_SUBB;
        end
      end
      ST_SUBB: begin
        if (borrow_i) begin
          finish_o = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          commit_b_o = 1'b1;
          state_d    = ST_SUBA;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish_o;
    end
  end

  assign done_o = done_q;

  // R4: the done pulse never lasts two cycles
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: a start seen mid-run does not send the machine back to the first phase
  a_r6_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUBA && start_i && !borrow_i) |=> (state_q == ST_SUBB));
endmodule

// File: rtl/oddsum_dp.sv
module oddsum_dp #(
  parameter int RAD_W  = 16,
  parameter int ROOT_W = RAD_W / 2,
  parameter int REM_W  = ROOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAD_W-1:0]  rad_i,
  input  logic              load_i,
  input  logic              phase_b_i,
  input  logic              commit_a_i,
  input  logic              commit_b_i,
  input  logic              finish_i,
  output logic              borrow_o,
  output logic [ROOT_W-1:0] root_o,
  output logic [REM_W-1:0]  rem_o
);
  localparam int DW  = ROOT_W + 1;
  localparam int PAD = RAD_W - DW;

  logic [RAD_W-1:0]  rem_q, rem_d, tmp_q, tmp_d;
  logic [DW-1:0]     div_q, div_d, div_inc;
  logic [ROOT_W-1:0] root_q, root_d;
  logic [REM_W-1:0]  remo_q, remo_d;
  logic [RAD_W-1:0]  op_a, op_b, diff;

  always_comb begin
    div_inc = div_q + 1'b1;
    op_a    = phase_b_i ? tmp_q : rem_q;
    op_b    = phase_b_i ? {{PAD{1'b0}}, div_inc} : {{PAD{1'b0}}, div_q};
  end

  oddsum_sub #(.W(RAD_W)) u_sub (
    .a_i      (op_a),
    .b_i      (op_b),
    .diff_o   (diff),
    .borrow_o (borrow_o)
  );

  always_comb begin
    rem_d  = rem_q;
    tmp_d  = tmp_q;
    div_d  = div_q;
    root_d = root_q;
    remo_d = remo_q;
    if (load_i) begin
      rem_d = rad_i;
      div_d = '0;
    end
    if (commit_a_i) tmp_d = diff;
    if (commit_b_i) begin
      rem_d = diff;
      div_d = div_inc;
    end
    if (finish_i) begin
      root_d = div_q[ROOT_W-1:0];
      remo_d = rem_q[REM_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      tmp_q  <= '0;
      div_q  <= '0;
      root_q <= '0;
      remo_q <= '0;
    end else begin
      if (load_i || commit_b_i) rem_q <= rem_d;
      if (commit_a_i)           tmp_q <= tmp_d;
      if (load_i || commit_b_i) div_q <= div_d;
      if (finish_i) begin
        root_q <= root_d;
        remo_q <= remo_d;
      end
    end
  end

  assign root_o = root_q;
  assign rem_o  = remo_q;

  // R8: an overdraft on a first subtraction is impossible while the divisor is zero
  a_r8_first_step_safe: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_i && !phase_b_i) |-> (div_q != '0));

  // R9: a completed step raises the divisor by exactly one
  a_r9_div_step: assert property (@(posedge clk) disable iff (!rst_n)
    commit_b_i |=> (div_q == $past(div_q) + 1'b1));

  // R5: results move only on the finishing edge
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !finish_i |=> ($stable(root_q) && $stable(remo_q)));

  // R3: a square-root remainder never exceeds twice the root
  a_r3_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    finish_i |=> ({1'b0, remo_q} <= {1'b0, root_q, 1'b0}));
endmodule

// File: rtl/oddsum_isqrt.sv
module oddsum_isqrt #(
  parameter int RAD_W  = 16,
  parameter int ROOT_W = RAD_W / 2,
  parameter int REM_W  = ROOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [RAD_W-1:0]  radicand_i,
  output logic              done_o,
  output logic [ROOT_W-1:0] root_o,
  output logic [REM_W-1:0]  rem_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       borrow, load, phase_b, commit_a, commit_b, finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  oddsum_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .borrow_i   (borrow),
    .load_o     (load),
    .phase_b_o  (phase_b),
    .commit_a_o (commit_a),
    .commit_b_o (commit_b),
    .finish_o   (finish),
    .done_o     (done_o)
  );

  oddsum_dp #(.RAD_W(RAD_W), .ROOT_W(ROOT_W), .REM_W(REM_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rad_i      (radicand_i),
    .load_i     (load),
    .phase_b_i  (phase_b),
    .commit_a_i (commit_a),
    .commit_b_i (commit_b),
    .finish_i   (finish),
    .borrow_o   (borrow),
    .root_o     (root_o),
    .rem_o      (rem_o)
  );
endmodule

// File: tb/oddsum_isqrt_tb.sv
`timescale 1ns/1ps
module oddsum_isqrt_tb;
  localparam int RAD_W  = 16;
  localparam int ROOT_W = RAD_W / 2;
  localparam int REM_W  = ROOT_W + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [RAD_W-1:0]  radicand_i = '0;
  logic              done_o;
  logic [ROOT_W-1:0] root_o;
  logic [REM_W-1:0]  rem_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  oddsum_isqrt #(.RAD_W(RAD_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .radicand_i(radicand_i),
    .done_o(done_o), .root_o(root_o), .rem_o(rem_o)
  );

  function automatic int ref_root(input int n);
    int r = 0;
    while ((r + 1) * (r + 1) <= n) r++;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one full computation; optional disturbing start at edge count 3
  task automatic run(input int n, input bit disturb, input int other);
    int r = ref_root(n);
    int e = n - r * r;
    int lat = (e < r) ? 2 * r + 1 : 2 * r + 2;
    int cnt = 0;
    int pulses = 0;
    int hr, hm;
    @(negedge clk);
    radicand_i = n[RAD_W-1:0];
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    while (cnt < 700) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (done_o) break;
      start_i = 1'b0;
      if (disturb && cnt == 3) begin
        radicand_i = other[RAD_W-1:0];
        start_i = 1'b1;
      end
    end
    start_i = 1'b0;
    check(done_o == 1'b1, "R4 done seen", int'(done_o), 1);
    check(int'(root_o) == r, disturb ? "R6 root after busy start" : "R2 root", int'(root_o), r);
    check(int'(rem_o) == e, disturb ? "R6 rem after busy start" : "R3 remainder", int'(rem_o), e);
    check(cnt == lat, "R7 R8 R9 latency", cnt, lat);
    hr = int'(root_o);
    hm = int'(rem_o);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done_o) pulses++;
      check(int'(root_o) == hr && int'(rem_o) == hm, "R5 hold", int'(root_o), hr);
    end
    check(pulses == 0, "R4 single pulse", pulses, 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done_o == 1'b0, "R1 done", int'(done_o), 0);
    check(root_o == '0, "R1 root", int'(root_o), 0);
    check(rem_o == '0, "R1 rem", int'(rem_o), 0);
    // R9: zero remainder midway does not stop the run
    run(16, 0, 0);
    run(0, 0, 0);
    run(1, 0, 0);
    run(15, 0, 0);
    run(17, 0, 0);
    run(20, 0, 0);
    run(24, 0, 0);
    run(65535, 0, 0);
    run(65025, 0, 0);
    // R6: second start with a different operand while busy
    run(10000, 1, 9);
    run(40000, 1, 3);
    for (int i = 0; i < 40; i++) begin
      int n = int'($urandom() & 32'hFFFF);
      if (i % 4 == 0) begin
        int s = int'($urandom() % 256);
        n = s * s;
      end
      run(n, (i % 5 == 0), 7);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule